// File: doc/BRIEF.md
# Video line and frame timing generator

This block derives raster timing for a 60 Hz or a 50 Hz video standard directly from the system clock. A fixed-point phase accumulator splits the clock into lines whose average length is a fractional number of clocks. On top of that it keeps a cycle-in-line count, a line-in-frame count and a running frame count. It produces a one-cycle line-start strobe, a vertical-blank level, a one-cycle vertical-blank interrupt request and the interlace field information that a display status word reports.

The line-start strobe and the blank level are meant to drive the clock and gate inputs of a neighbouring timer block. The interrupt request goes to an interrupt controller, and the field and status bits go to the display status register. The standard select is sampled only when a frame wraps, so software can change it at any time without producing a malformed frame.

Top module: `vtg_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the line count, cycle count and frame count are 0, the line strobe, blank level, interrupt and field bit are 0, the odd-status bit is 0 and the even-status bit is 1.
- R2: Line length comes from a phase accumulator with FRAC_W fraction bits. With the increment INC of the active standard (std_sel_i 0 selects INC_60, 1 selects INC_50), the k-th line after reset ends on clock edge ceil(k*INC/2^FRAC_W), so the remainder is carried from line to line and the long-run line period is exactly INC/2^FRAC_W clocks.
- R3: hsync_o is high for exactly one cycle at the start of each line, in the cycle where the cycle-in-line count reads 0; otherwise that count rises by one each clock.
- R4: A frame holds LINES_60 lines in the 60 Hz standard and LINES_50 lines in the 50 Hz standard; after the last line the line count returns to 0 and the frame count rises by one.
- R5: vblank_o is high from the start of line VBL_LINE until the frame wraps to line 0.
- R6: vblank_irq_o pulses for one cycle, together with the line strobe, when line VBL_LINE is entered, once per frame.
- R7: At each frame wrap the field bit toggles when both bits of ilace_en_i are 1 (value 2'b11); for any other value it becomes 0 at the wrap.
- R8: stat_odd_o is cleared when line VBL_LINE is entered; at each frame wrap stat_odd_o takes the new field bit and stat_even_o its inverse.
- R9: A change of std_sel_i takes effect at the next frame wrap; the frame in progress keeps the line count and line length of the standard it started with.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| std_sel_i | input | 1 | Standard select: 0 = 60 Hz, 1 = 50 Hz |
| ilace_en_i | input | 2 | Interlace enables; field toggling needs both set |
| cyc_o | output | CYC_W | Cycle position inside the current line |
| line_o | output | LINE_W | Line position inside the current frame |
| frame_o | output | FRAME_W | Running frame count |
| hsync_o | output | 1 | One-cycle line-start strobe |
| vblank_o | output | 1 | Vertical-blank level |
| vblank_irq_o | output | 1 | One-cycle vertical-blank interrupt request |
| field_o | output | 1 | Current interlace field |
| stat_odd_o | output | 1 | Status bit 31: field, cleared at blank start |
| stat_even_o | output | 1 | Status bit 13: inverse of the field |

## Verification
Frames are measured under a fractional increment (10.5 clocks per line) and an integral one (13 clocks per line) with small line counts, so both the alternating line lengths and the exact frame totals show whether the remainder is carried. Each standard is paired with every interlace-enable value, which separates true toggling (both bits) from a single-bit enable. Switching the standard just after a wrap checks that the frame in progress keeps its old line count, and a directed run from reset checks the exact edges of the first line strobes.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
   typedef enum logic {
      VSTD_60 = 1'b0,
      VSTD_50 = 1'b1
   } vstd_e;

   localparam logic [1:0] ILACE_BOTH = 2'b11;
endpackage

// File: rtl/vtg_line_acc.sv
module vtg_line_acc #(
   parameter int unsigned FRAC_W = 12,
   parameter int unsigned ACC_W  = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ACC_W-1:0] inc_i,
   output logic             tick_o
);
   localparam logic [ACC_W:0] ONE = (ACC_W+1)'(1) << FRAC_W;

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W:0]   sum;
   logic [ACC_W:0]   acc_d;

   always_comb begin
      sum    = {1'b0, acc_q} + ONE;
      tick_o = (sum >= {1'b0, inc_i});
      acc_d  = tick_o ? (sum - {1'b0, inc_i}) : sum;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_d[ACC_W-1:0];
   end
endmodule

// File: rtl/vtg_line_tmr.sv
module vtg_line_tmr #(
   parameter int unsigned CYC_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   output logic [CYC_W-1:0] cyc_o,
   output logic             hsync_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cyc_o   <= '0;
         hsync_o <= 1'b0;
      end else begin
         cyc_o   <= tick_i ? '0 : cyc_o + 1'b1;
         hsync_o <= tick_i;
      end
   end
endmodule

// File: rtl/vtg_frame_seq.sv
module vtg_frame_seq
   import vtg_pkg::*;
#(
   parameter int unsigned LINES_60 = 263,
   parameter int unsigned LINES_50 = 314,
   parameter int unsigned VBL_LINE = 240,
   parameter int unsigned LINE_W   = 9,
   parameter int unsigned FRAME_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_i,
   input  logic               std_sel_i,
   output logic [LINE_W-1:0]  line_o,
   output logic [FRAME_W-1:0] frame_o,
   output vstd_e              std_act_o,
   output logic               wrap_o,
   output logic               vbl_enter_o,
   output logic               irq_o
);
   localparam logic [LINE_W-1:0] LAST_60 = LINE_W'(LINES_60 - 1);
   localparam logic [LINE_W-1:0] LAST_50 = LINE_W'(LINES_50 - 1);
   localparam logic [LINE_W-1:0] PRE_VBL = LINE_W'(VBL_LINE - 1);

   logic [LINE_W-1:0] last_line;

   always_comb begin
      last_line   = (std_act_o == VSTD_50) ? LAST_50 : LAST_60;
      wrap_o      = tick_i && (line_o == last_line);
      vbl_enter_o = tick_i && !wrap_o && (line_o == PRE_VBL);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_o    <= '0;
         frame_o   <= '0;
         std_act_o <= VSTD_60;
         irq_o     <= 1'b0;
      end else begin
         irq_o <= vbl_enter_o;
         if (wrap_o) begin
            line_o    <= '0;
            frame_o   <= frame_o + 1'b1;
            std_act_o <= vstd_e'(std_sel_i);
         end else if (tick_i) begin
            line_o <= line_o + 1'b1;
         end
      end
   end
endmodule

// File: rtl/vtg_field.sv
module vtg_field
   import vtg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wrap_i,
   input  logic       vbl_enter_i,
   input  logic [1:0] ilace_en_i,
   output logic       field_o,
   output logic       stat_odd_o,
   output logic       stat_even_o
);
   logic next_field;

   always_comb begin
      next_field = (ilace_en_i == ILACE_BOTH) ? !field_o : 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         field_o     <= 1'b0;
         stat_odd_o  <= 1'b0;
         stat_even_o <= 1'b1;
      end else if (wrap_i) begin
         field_o     <= next_field;
         stat_odd_o  <= next_field;
         stat_even_o <= !next_field;
      end else if (vbl_enter_i) begin
         stat_odd_o  <= 1'b0;
      end
   end
endmodule

// File: rtl/vtg_top.sv
module vtg_top
   import vtg_pkg::*;
#(
   parameter int unsigned FRAC_W   = 12,
   parameter int unsigned ACC_W    = 24,
   parameter int unsigned INC_60   = 8791293,
   parameter int unsigned INC_50   = 8836089,
   parameter int unsigned LINES_60 = 263,
   parameter int unsigned LINES_50 = 314,
   parameter int unsigned VBL_LINE = 240,
   parameter int unsigned CYC_W    = 12,
   parameter int unsigned LINE_W   = 9,
   parameter int unsigned FRAME_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               std_sel_i,
   input  logic [1:0]         ilace_en_i,
   output logic [CYC_W-1:0]   cyc_o,
   output logic [LINE_W-1:0]  line_o,
   output logic [FRAME_W-1:0] frame_o,
   output logic               hsync_o,
   output logic               vblank_o,
   output logic               vblank_irq_o,
   output logic               field_o,
   output logic               stat_odd_o,
   output logic               stat_even_o
);
   localparam longint unsigned ONE     = 64'd1 << FRAC_W;
   localparam longint unsigned INC_MAX = (INC_60 > INC_50) ? INC_60 : INC_50;
   localparam longint unsigned INC_MIN = (INC_60 < INC_50) ? INC_60 : INC_50;
   localparam longint unsigned CYC_MAX = (INC_MAX + ONE - 1) / ONE;
   localparam int unsigned     LN_MIN  = (LINES_60 < LINES_50) ? LINES_60 : LINES_50;
   localparam int unsigned     LN_MAX  = (LINES_60 > LINES_50) ? LINES_60 : LINES_50;
   localparam logic [ACC_W-1:0] INC_TBL [2] = '{ACC_W'(INC_60), ACC_W'(INC_50)};

   if (INC_MIN < 2 * ONE) begin : g_bad_inc
      $error("line increment must cover at least two clocks");
   end
   if (INC_MAX >= (64'd1 << ACC_W)) begin : g_bad_acc
      $error("ACC_W too narrow for the increments");
   end
   if (CYC_MAX > (64'd1 << CYC_W)) begin : g_bad_cyc
      $error("CYC_W too narrow for the line length");
   end
   if (LN_MAX > (1 << LINE_W)) begin : g_bad_line
      $error("LINE_W too narrow for the frame");
   end
   if (VBL_LINE == 0 || VBL_LINE >= LN_MIN) begin : g_bad_vbl
      $error("VBL_LINE must fall inside every frame");
   end

   vstd_e std_act;
   logic  tick;
   logic  wrap;
   logic  vbl_enter;

   vtg_line_acc #(.FRAC_W(FRAC_W), .ACC_W(ACC_W)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc_i  (INC_TBL[std_act]),
      .tick_o (tick)
   );

   vtg_line_tmr #(.CYC_W(CYC_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick),
      .cyc_o   (cyc_o),
      .hsync_o (hsync_o)
   );

   vtg_frame_seq #(
      .LINES_60 (LINES_60),
      .LINES_50 (LINES_50),
      .VBL_LINE (VBL_LINE),
      .LINE_W   (LINE_W),
      .FRAME_W  (FRAME_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick),
      .std_sel_i   (std_sel_i),
      .line_o      (line_o),
      .frame_o     (frame_o),
      .std_act_o   (std_act),
      .wrap_o      (wrap),
      .vbl_enter_o (vbl_enter),
      .irq_o       (vblank_irq_o)
   );

   vtg_field u_fld (
      .clk         (clk),
      .rst_n       (rst_n),
      .wrap_i      (wrap),
      .vbl_enter_i (vbl_enter),
      .ilace_en_i  (ilace_en_i),
      .field_o     (field_o),
      .stat_odd_o  (stat_odd_o),
      .stat_even_o (stat_even_o)
   );

   assign vblank_o = (line_o >= LINE_W'(VBL_LINE));
endmodule

// File: rtl/vtg_top_chk.sv
module vtg_top_chk #(
   parameter int unsigned VBL_LINE = 240,
   parameter int unsigned CYC_W    = 12,
   parameter int unsigned LINE_W   = 9,
   parameter int unsigned FRAME_W  = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic [CYC_W-1:0]   cyc_o,
   input logic [LINE_W-1:0]  line_o,
   input logic [FRAME_W-1:0] frame_o,
   input logic               hsync_o,
   input logic               vblank_o,
   input logic               vblank_irq_o,
   input logic               field_o,
   input logic               stat_odd_o,
   input logic               stat_even_o
);
   logic past_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assert_hsync_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hsync_o |-> (cyc_o == '0));

   assert_hsync_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hsync_o |=> !hsync_o);

   assert_cyc_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !hsync_o) |-> (cyc_o == CYC_W'($past(cyc_o) + 1'b1)));

   assert_line_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !hsync_o) |-> $stable(line_o));

   assert_wrap_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && hsync_o && line_o == '0) |-> (frame_o == FRAME_W'($past(frame_o) + 1'b1)));

   assert_blank_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $rose(vblank_o)) |-> vblank_irq_o);

   assert_irq_at_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
      vblank_irq_o |-> (hsync_o && line_o == LINE_W'(VBL_LINE)));

   assert_odd_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
      vblank_irq_o |-> !stat_odd_o);

   assert_wrap_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hsync_o && line_o == '0) |-> (stat_odd_o == field_o && stat_even_o == !field_o));
endmodule

bind vtg_top vtg_top_chk #(
   .VBL_LINE (VBL_LINE),
   .CYC_W    (CYC_W),
   .LINE_W   (LINE_W),
   .FRAME_W  (FRAME_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cyc_o        (cyc_o),
   .line_o       (line_o),
   .frame_o      (frame_o),
   .hsync_o      (hsync_o),
   .vblank_o     (vblank_o),
   .vblank_irq_o (vblank_irq_o),
   .field_o      (field_o),
   .stat_odd_o   (stat_odd_o),
   .stat_even_o  (stat_even_o)
);

// File: tb/vtg_top_tb_top.sv
`timescale 1ns/1ps
module vtg_top_tb_top;
   localparam int unsigned FRAC_W   = 12;
   localparam int unsigned ACC_W    = 24;
   localparam int unsigned INC_60   = 43008;
   localparam int unsigned INC_50   = 53248;
   localparam int unsigned LINES_60 = 12;
   localparam int unsigned LINES_50 = 15;
   localparam int unsigned VBL_LINE = 8;
   localparam int unsigned CYC_W    = 8;
   localparam int unsigned LINE_W   = 5;
   localparam int unsigned FRAME_W  = 8;

   typedef struct packed {
      logic       std;
      logic [1:0] il;
      int         lines;
      int         cycles;
      int         vbc;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 2'b00, 12, 126, 42},
      '{1'b1, 2'b11, 15, 195, 91},
      '{1'b0, 2'b11, 12, 126, 42},
      '{1'b1, 2'b01, 15, 195, 91},
      '{1'b0, 2'b10, 12, 126, 42},
      '{1'b1, 2'b00, 15, 195, 91}
   };

   logic               clk = 1'b0;
   logic               rst_n;
   logic               std_sel_i;
   logic [1:0]         ilace_en_i;
   logic [CYC_W-1:0]   cyc_o;
   logic [LINE_W-1:0]  line_o;
   logic [FRAME_W-1:0] frame_o;
   logic               hsync_o, vblank_o, vblank_irq_o;
   logic               field_o, stat_odd_o, stat_even_o;

   int n_chk = 0;
   int n_bad = 0;
   int n_cyc = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   vtg_top #(
      .FRAC_W(FRAC_W), .ACC_W(ACC_W), .INC_60(INC_60), .INC_50(INC_50),
      .LINES_60(LINES_60), .LINES_50(LINES_50), .VBL_LINE(VBL_LINE),
      .CYC_W(CYC_W), .LINE_W(LINE_W), .FRAME_W(FRAME_W)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .std_sel_i(std_sel_i), .ilace_en_i(ilace_en_i),
      .cyc_o(cyc_o), .line_o(line_o), .frame_o(frame_o), .hsync_o(hsync_o),
      .vblank_o(vblank_o), .vblank_irq_o(vblank_irq_o), .field_o(field_o),
      .stat_odd_o(stat_odd_o), .stat_even_o(stat_even_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic to_wrap();
      for (int i = 0; i < 1000; i++) begin
         step();
         if (hsync_o && line_o == 0) return;
      end
      chk(1'b0, "R4 wrap not seen", 0, 1);
   endtask

   task automatic measure(output int lines, output int cycles, output int vbc, output int irqs);
      lines = 0; cycles = 0; vbc = 0; irqs = 0;
      for (int i = 0; i < 1000; i++) begin
         step();
         cycles++;
         if (hsync_o) lines++;
         if (vblank_o) vbc++;
         if (vblank_irq_o) irqs++;
         if (hsync_o && line_o == 0) return;
      end
      chk(1'b0, "R4 frame end not seen", cycles, 0);
   endtask

   task automatic finish_up();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      n_cyc++;
      if (n_cyc > 100000 && !done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", n_cyc, 100000);
         finish_up();
      end
   end

   initial begin
      int  lt, ln, cy, vb, ir;
      int  prev_lines;
      bit  f1, ef;
      rst_n      = 1'b0;
      std_sel_i  = 1'b0;
      ilace_en_i = 2'b00;
      repeat (3) step();

      // R1 reset state
      chk(line_o == 0 && cyc_o == 0 && frame_o == 0, "R1 counters", int'(line_o), 0);
      chk(!hsync_o && !vblank_o && !vblank_irq_o, "R1 strobes", int'(hsync_o), 0);
      chk(!field_o && !stat_odd_o && stat_even_o, "R1 status", int'({field_o, stat_odd_o, stat_even_o}), 1);

      // R2/R3 first lines from reset: strobes after edges 11, 21, 32, 42
      rst_n = 1'b1;
      for (int n = 1; n <= 42; n++) begin
         step();
         if (n == 11 || n == 21 || n == 32 || n == 42)
            chk(hsync_o == 1'b1, "R2 strobe edge", n, 1);
         else if (n == 10 || n == 20 || n == 31 || n == 41)
            chk(hsync_o == 1'b0, "R2 no early strobe", n, 0);
         if (n == 10) chk(cyc_o == 10, "R3 count before strobe", int'(cyc_o), 10);
         if (n == 11) chk(cyc_o == 0 && line_o == 1, "R3 count at strobe", int'(cyc_o), 0);
         if (n == 12) chk(hsync_o == 1'b0 && cyc_o == 1, "R3 single strobe", int'(cyc_o), 1);
      end

      // vector table walk: R4 R2 R5 R6 R7 R8 R9
      to_wrap();
      prev_lines = LINES_60;
      for (int v = 0; v < NV; v++) begin
         std_sel_i  = VEC[v].std;
         ilace_en_i = VEC[v].il;
         measure(lt, cy, vb, ir);
         chk(lt == prev_lines, "R9 frame keeps old standard", lt, prev_lines);
         f1 = field_o;
         measure(ln, cy, vb, ir);
         chk(ln == VEC[v].lines, "R4 lines per frame", ln, VEC[v].lines);
         chk(cy == VEC[v].cycles, "R2 clocks per frame", cy, VEC[v].cycles);
         chk(vb == VEC[v].vbc, "R5 blank clocks", vb, VEC[v].vbc);
         chk(ir == 1, "R6 one interrupt per frame", ir, 1);
         ef = (VEC[v].il == 2'b11) ? !f1 : 1'b0;
         chk(field_o == ef, "R7 field at wrap", int'(field_o), int'(ef));
         chk(stat_odd_o == ef && stat_even_o == !ef, "R8 status at wrap",
             int'({stat_odd_o, stat_even_o}), int'({ef, !ef}));
         prev_lines = VEC[v].lines;
      end

      // R8 odd bit cleared on blank entry
      std_sel_i  = 1'b0;
      ilace_en_i = 2'b11;
      to_wrap();
      if (!stat_odd_o) to_wrap();
      chk(stat_odd_o == 1'b1, "R8 odd set at wrap", int'(stat_odd_o), 1);
      for (int i = 0; i < 500 && !vblank_irq_o; i++) begin
         step();
         if (!vblank_irq_o && line_o < VBL_LINE)
            if (!stat_odd_o) chk(1'b0, "R8 odd held before blank", 0, 1);
      end
      chk(vblank_irq_o && line_o == VBL_LINE, "R6 interrupt line", int'(line_o), VBL_LINE);
      chk(stat_odd_o == 1'b0 && vblank_o, "R8 odd cleared at blank", int'(stat_odd_o), 0);
      step();
      chk(vblank_irq_o == 1'b0 && vblank_o, "R6 pulse width", int'(vblank_irq_o), 0);

      // R1 reset mid-run
      rst_n = 1'b0;
      step();
      chk(line_o == 0 && frame_o == 0 && !field_o && !stat_odd_o && stat_even_o,
          "R1 mid-run reset", int'(line_o), 0);

      finish_up();
   end
endmodule